// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a single-cycle processor and updates it on every clock edge. The instruction decoder supplies a load-enable bit, a jump/branch select bit, a 3-bit condition code and a signed 6-bit address offset. The register file supplies a full-width jump target. The ALU supplies four status flags: carry, negative, overflow and zero. From these inputs the unit picks one of three moves each cycle. It can step forward by one, jump unconditionally to the target, or take a PC-relative branch when the chosen flag test is true.

Inside the unit, a control module turns the decoded fields and the flags into a small set of strobes. A datapath module holds the counter register and computes the address arithmetic. The condition code picks one flag and says whether the branch needs that flag set or clear, which gives eight tests.

Top module: `pc_next_unit`

## Requirements
- R1: With `loadEn` = 0, `pcOut` becomes `pcOut + 1` at the next clock edge.
- R2: With `loadEn` = 1 and `jumpSel` = 1, `pcOut` takes the full 16-bit `jumpTarget` at the next edge, whatever the flags and the condition code are.
- R3: With `loadEn` = 1 and `jumpSel` = 0, the unit makes a conditional branch. The branch is taken exactly when the flag test chosen by `condSel` is true.
- R4: `condSel` values 3'b000, 3'b001, 3'b010 and 3'b011 test that carry, negative, overflow and zero (in that order) are 1.
- R5: `condSel` values 3'b100, 3'b101, 3'b110 and 3'b111 test that carry, negative, overflow and zero (in that order) are 0.
- R6: A taken branch sign-extends the 6-bit two's-complement `branchOfs` to 16 bits and adds it to `pcOut`, wrapping modulo 2^16. A branch of -20 from 100 lands on 80, and the same branch from 5 lands on 0xFFF1.
- R7: A conditional branch whose test is false increments `pcOut` by one.
- R8: When `rst` = 1 at a clock edge, `pcOut` becomes 0, whatever the other inputs are.
- R9: Incrementing from 0xFFFF wraps `pcOut` to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | 0: step by one; 1: jump or branch |
| jumpSel | input | 1 | With loadEn: 1 for jump, 0 for conditional branch |
| condSel | input | 3 | Bit 2 inverts the test; bits 1:0 pick C, N, V, Z |
| branchOfs | input | 6 | Signed branch offset |
| jumpTarget | input | 16 | Absolute jump address from a register |
| flagC | input | 1 | Carry flag |
| flagN | input | 1 | Negative flag |
| flagV | input | 1 | Overflow flag |
| flagZ | input | 1 | Zero flag |
| pcOut | output | 16 | Current program counter |

## Verification
All state in this unit is the counter itself, so any fault shows up on `pcOut` at the clock edge right after the bad decision. Examples of such faults are a wrong flag picked by the condition code, a missing inversion, an offset that is not sign-extended, or a jump that loses upper bits. Because the bench tracks the expected counter every cycle, one wrong step leaves a difference from the model on the next sample. The bench sets that counter to known values with jumps, so later checks start from a known state again. The corner cases are the -20 backward branch, including one that wraps below zero, the 0xFFFF increment, and reset asserted while a jump is requested.

// File: rtl/pc_next_pkg.sv
package pc_next_pkg;

  // Strobes from control to datapath; both low means sequential step.
  typedef struct packed {
    logic doJump;
    logic doBranch;
  } pcStrobe_t;

  // Index of each flag within the packed flag vector.
  typedef enum logic [1:0] {
    FLAG_CARRY = 2'd0,
    FLAG_NEG   = 2'd1,
    FLAG_OVF   = 2'd2,
    FLAG_ZERO  = 2'd3
  } flagIdx_t;

  localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/pc_next_ctrl.sv
module pc_next_ctrl
  import pc_next_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 loadEn,
  input  logic                 jumpSel,
  input  logic [2:0]           condSel,
  input  logic [NUM_FLAGS-1:0] flagVec,
  output pcStrobe_t            strobe
);

  logic     flagPicked;
  logic     testTrue;
  flagIdx_t flagIdx;

  assign flagIdx    = flagIdx_t'(condSel[1:0]);
  assign flagPicked = flagVec[flagIdx];
  // Bit 2 of the condition code asks for the flag to be clear.
  assign testTrue   = condSel[2] ? ~flagPicked : flagPicked;

  always_comb begin
    strobe = '0;
    if (loadEn) begin
      if (jumpSel) strobe.doJump   = 1'b1;
      else         strobe.doBranch = testTrue;
    end
  end

  AST_JUMP_STROBE: assert property (@(posedge clk) disable iff (rst)
    (loadEn && jumpSel) |-> (strobe.doJump && !strobe.doBranch)) else $error("jump strobe"); // R2
  AST_SEQ_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !loadEn |-> (strobe == '0)) else $error("seq strobe"); // R1
  AST_CARRY_SET: assert property (@(posedge clk) disable iff (rst)
    (loadEn && !jumpSel && condSel == 3'b000) |-> (strobe.doBranch == flagVec[0])) else $error("carry set"); // R4
  AST_ZERO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (loadEn && !jumpSel && condSel == 3'b111) |-> (strobe.doBranch == !flagVec[3])) else $error("zero clear"); // R5

endmodule

// File: rtl/pc_next_dp.sv
module pc_next_dp
  import pc_next_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  pcStrobe_t        strobe,
  input  logic [OFS_W-1:0] branchOfs,
  input  logic [PC_W-1:0]  jumpTarget,
  output logic [PC_W-1:0]  pcOut
);

  localparam int EXT_W = PC_W - OFS_W;

  logic [PC_W-1:0] pcReg;
  logic [PC_W-1:0] ofsExt;
  logic [PC_W-1:0] pcInc;
  logic [PC_W-1:0] pcRel;
  logic [PC_W-1:0] pcNext;

  assign ofsExt = {{EXT_W{branchOfs[OFS_W-1]}}, branchOfs};
  assign pcInc  = pcReg + PC_W'(1);
  assign pcRel  = pcReg + ofsExt;

  always_comb begin
    if (strobe.doJump)        pcNext = jumpTarget;
    else if (strobe.doBranch) pcNext = pcRel;
    else                      pcNext = pcInc;
  end

  always_ff @(posedge clk) begin
    if (rst) pcReg <= '0;
    else     pcReg <= pcNext;
  end

  assign pcOut = pcReg;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pcReg == '0)) else $error("reset"); // R8
  AST_JUMP_LOADS: assert property (@(posedge clk) disable iff (rst)
    strobe.doJump |=> (pcReg == $past(jumpTarget))) else $error("jump"); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (strobe == '0) |=> (pcReg == $past(pcReg) + PC_W'(1))) else $error("step"); // R7
  AST_REL_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (strobe.doBranch && !strobe.doJump) |=>
      (pcReg == $past(pcReg) + {{EXT_W{$past(branchOfs[OFS_W-1])}}, $past(branchOfs)})) else $error("branch"); // R6

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pc_next_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadEn,
  input  logic             jumpSel,
  input  logic [2:0]       condSel,
  input  logic [OFS_W-1:0] branchOfs,
  input  logic [PC_W-1:0]  jumpTarget,
  input  logic             flagC,
  input  logic             flagN,
  input  logic             flagV,
  input  logic             flagZ,
  output logic [PC_W-1:0]  pcOut
);

  pcStrobe_t            strobe;
  logic [NUM_FLAGS-1:0] flagVec;

  assign flagVec = {flagZ, flagV, flagN, flagC};

  pc_next_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .loadEn  (loadEn),
    .jumpSel (jumpSel),
    .condSel (condSel),
    .flagVec (flagVec),
    .strobe  (strobe)
  );

  pc_next_dp #(.PC_W(PC_W), .OFS_W(OFS_W)) uDp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .branchOfs  (branchOfs),
    .jumpTarget (jumpTarget),
    .pcOut      (pcOut)
  );

endmodule

// File: tb/tb_pc_next_unit.sv
module tb_pc_next_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        loadEn, jumpSel, flagC, flagN, flagV, flagZ;
  logic [2:0]  condSel;
  logic [5:0]  branchOfs;
  logic [15:0] jumpTarget;
  logic [15:0] pcOut;

  int errors = 0;
  int checks = 0;
  logic [15:0] expPc;
  string curReq;

  always #4 clk = ~clk;

  pc_next_unit dut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .jumpSel(jumpSel), .condSel(condSel),
    .branchOfs(branchOfs), .jumpTarget(jumpTarget), .flagC(flagC), .flagN(flagN),
    .flagV(flagV), .flagZ(flagZ), .pcOut(pcOut)
  );

  function automatic logic testOf(logic [2:0] cs, logic c, logic n, logic v, logic z);
    logic f;
    case (cs[1:0])
      2'd0: f = c;
      2'd1: f = n;
      2'd2: f = v;
      default: f = z;
    endcase
    return cs[2] ? !f : f;
  endfunction

  function automatic logic [15:0] modelNext(logic [15:0] pc);
    if (rst) return 16'h0;
    if (!loadEn) return pc + 16'd1;
    if (jumpSel) return jumpTarget;
    if (testOf(condSel, flagC, flagN, flagV, flagZ))
      return pc + {{10{branchOfs[5]}}, branchOfs};
    return pc + 16'd1;
  endfunction

  function automatic string reqOf();
    if (rst) return "R8";
    if (!loadEn) return (expPc == 16'hFFFF) ? "R9" : "R1";
    if (jumpSel) return "R2";
    if (testOf(condSel, flagC, flagN, flagV, flagZ))
      return condSel[2] ? "R5/R3/R6" : "R4/R3/R6";
    return condSel[2] ? "R5/R7" : "R4/R7";
  endfunction

  // Drive one cycle: inputs set at negedge, result checked at next negedge.
  task automatic step(logic r, logic le, logic js, logic [2:0] cs, logic [5:0] ofs,
                      logic [15:0] tgt, logic [3:0] zvnc);
    rst = r; loadEn = le; jumpSel = js; condSel = cs; branchOfs = ofs; jumpTarget = tgt;
    {flagZ, flagV, flagN, flagC} = zvnc;
    curReq = reqOf();
    expPc  = modelNext(expPc);
    @(negedge clk);
    checks++;
    if (pcOut !== expPc) begin
      errors++;
      $display("FAIL %s: pcOut=%h expected=%h", curReq, pcOut, expPc);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: pcOut=%h expected=%h", pcOut, expPc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    expPc = 16'h0;
    @(negedge clk);
    // R8: reset state, and reset beats a requested jump
    step(1, 0, 0, 3'b000, 6'd0, 16'h0, 4'h0);
    step(0, 1, 1, 3'b000, 6'd0, 16'h1234, 4'h0);       // R2
    step(1, 1, 1, 3'b000, 6'd0, 16'hBEEF, 4'hF);       // R8 priority
    step(0, 0, 0, 3'b000, 6'd0, 16'h0, 4'h0);          // R1
    // R6: -20 backward branch from 100 -> 80 (Z set, cond 011)
    step(0, 1, 1, 3'b000, 6'd0, 16'd100, 4'h0);
    step(0, 1, 0, 3'b011, 6'b101100, 16'h0, 4'b1000);
    // R6 wrap: 5 - 20 = 0xFFF1
    step(0, 1, 1, 3'b000, 6'd0, 16'd5, 4'h0);
    step(0, 1, 0, 3'b011, 6'b101100, 16'h0, 4'b1000);
    // R9: FFFF increments to 0
    step(0, 1, 1, 3'b000, 6'd0, 16'hFFFF, 4'h0);
    step(0, 0, 1, 3'b111, 6'd7, 16'h5555, 4'hF);
    // R4/R5: each code with its flag alone set, then all others
    for (int cs = 0; cs < 8; cs++) begin
      for (int f = 0; f < 4; f++) begin
        step(0, 1, 1, 3'b000, 6'd0, 16'h0200, 4'h0);
        step(0, 1, 0, 3'(cs), 6'd9, 16'h0, 4'(1 << f));  // taken iff f matches, inverted by bit 2
      end
    end
    // Random mix
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step((r[3:0] == 4'd0), r[4] | r[5], r[6] & r[7], r[10:8], r[16:11],
           $urandom, r[20:17]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule